// File: doc/BRIEF.md
# Watchdog Timer with Qualified Feed

This block supervises a processor by counting clock cycles since the last valid feed. If no valid feed arrives within the configured timeout, it asserts an active-low system reset and emits a single-cycle strobe. A higher-level escalation controller can use that strobe. The timeout, the minimum feed width and the minimum reset width are given in microseconds. They are converted to cycle counts from a clock-frequency parameter. The defaults are 200 ms, 40 µs and 100 ms.

A feed only counts once the input has stayed high for the minimum width. Narrow glitches therefore leave the timer untouched. There is no early-feed window: any qualified feed restarts the count. The reset output obeys several supply interlocks:

- It is stretched to a guaranteed minimum width.
- It is forced low at once by a brown-out flag.
- Its release waits for power-good.
- Feeds that arrive during a supply dip are discarded.

A test input parks the timer so that no timeout can occur. All inputs except the asynchronous reset are taken to be synchronous to the clock.

Top module: `wdog_guard`

## Requirements
- R1: While `rst_n` is low, and for the full stretch period after it releases, `reset_n` is low and `timeout_pulse` is low.
- R2: A feed is accepted only after `feed` has been sampled high on KICK consecutive rising edges. A shorter high pulse has no effect on the timeout count.
- R3: A single high pulse yields at most one acceptance, however long it lasts. Another acceptance requires `feed` to return low first.
- R4: There is no window. A feed accepted at any time restarts the count from zero, and the strobe follows TO+1 cycles after the last accepting edge.
- R5: On expiry, `timeout_pulse` (active high) is high for exactly one cycle.
- R6: After a strobe, `reset_n` goes low on the next edge. It stays low for RST cycles and, if power is good, rises on the edge after that.
- R7: `brownout` high drives `reset_n` low in the same cycle, overriding every other condition. It also reloads the stretch, so release comes RST edges after the last edge at which brownout was high.
- R8: Once the stretch has elapsed, `reset_n` stays low while `power_good` is low. It rises on the first edge that samples `power_good` high.
- R9: Feed pulses seen while `power_good` is low or `brownout` is high are ignored.
- R10: While `test_disable` is high, the counter is held at zero and no strobe is produced. After it falls, the strobe comes TO edges later unless a feed intervenes.
- R11: When `reset_n` releases, the count restarts from zero. Without a feed, the strobe comes TO edges after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| feed | input | 1 | Feed (kick) input, active high |
| power_good | input | 1 | Supply valid; gates reset release and feeds |
| brownout | input | 1 | Supply under threshold; forces reset |
| test_disable | input | 1 | Holds the timer cleared when high |
| reset_n | output | 1 | Active-low system reset |
| timeout_pulse | output | 1 | One-cycle strobe at timeout expiry |

## Verification
The hardest case to reach from the ports is a timeout that expires while `power_good` is low. The stretch counter has to run out first, so that the reset is held only by the missing supply, and a feed must be offered during the dip as well. The stimulus lets a qualified feed start the count and then drops `power_good` well before expiry. It sends two full-width pulses that must not shift the expected strobe. It raises `power_good` again only 15 cycles after the stretch ends, so a release that ignored power-good would show up as a cycle mismatch. Every strobe and every release is compared against an exact cycle stamp.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Convert a duration in microseconds to a count of clock cycles.
  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    longint unsigned prod;
    prod = (hz * us) / 64'd1_000_000;
    return prod[31:0];
  endfunction

endpackage

// File: rtl/wdg_feed_qual.sv
module wdg_feed_qual #(
  parameter int KICK_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic feed,
  input  logic power_good,
  input  logic brownout,
  output logic accept
);
  localparam int KW = $clog2(KICK_CYC + 1);
  localparam logic [KW-1:0] LAST = KW'(KICK_CYC - 1);

  logic [KW-1:0] wcnt_q, wcnt_d;
  logic          spent_q, spent_d;
  logic          acc_q, hit, blocked;

  always_comb begin
    blocked = !power_good || brownout;
    hit     = feed && !blocked && !spent_q && (wcnt_q == LAST);
    wcnt_d  = wcnt_q;
    spent_d = spent_q;
    if (!feed) begin
      wcnt_d  = '0;
      spent_d = 1'b0;
    end else if (blocked || hit) begin
      wcnt_d  = '0;
      spent_d = 1'b1;
    end else if (!spent_q) begin
      wcnt_d  = wcnt_q + KW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      spent_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_d;
      spent_q <= spent_d;
      acc_q   <= hit;
    end
  end

  assign accept = acc_q;

  a_r3_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> !acc_q);
  a_r9_dip_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> ($past(power_good) && !$past(brownout)));
  a_r2_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> $past(feed));

endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout #(
  parameter int TO_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  input  logic disable_i,
  output logic expire
);
  localparam int TW = $clog2(TO_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TO_CYC - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          exp_q, exp_d, clr, at_end;

  always_comb begin
    clr    = disable_i || restart || hold;
    at_end = (tcnt_q == LAST);
    exp_d  = !clr && at_end;
    if (clr || at_end) tcnt_d = '0;
    else               tcnt_d = tcnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      exp_q  <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      exp_q  <= exp_d;
    end
  end

  assign expire = exp_q;

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);
  a_r10_parked: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !exp_q);
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tcnt_q == '0));

endmodule

// File: rtl/wdg_rst_stretch.sv
module wdg_rst_stretch #(
  parameter int RST_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic power_good,
  input  logic brownout,
  output logic hold
);
  localparam int SW = $clog2(RST_CYC + 1);
  localparam logic [SW-1:0] LOAD = SW'(RST_CYC - 1);

  logic [SW-1:0] scnt_q, scnt_d;
  logic          hold_q, hold_d;
  logic          load, dec, rel;

  always_comb begin
    load   = brownout || expire;
    dec    = !load && hold_q && (scnt_q != '0);
    rel    = !load && hold_q && (scnt_q == '0) && power_good;
    hold_d = load ? 1'b1 : (rel ? 1'b0 : hold_q);
    scnt_d = load ? LOAD : (scnt_q - SW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= LOAD;
      hold_q <= 1'b1;
    end else begin
      hold_q <= hold_d;
      if (load || dec) scnt_q <= scnt_d;
    end
  end

  assign hold = hold_q;

  a_r6_expire_holds: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> hold_q);
  a_r7_bo_reload: assert property (@(posedge clk) disable iff (!rst_n)
    brownout |=> (hold_q && scnt_q == LOAD));
  a_r8_release_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && $past(hold_q)) |-> ($past(power_good) && !$past(brownout)));
  a_r6_full_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && $past(hold_q)) |-> ($past(scnt_q) == '0));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 1_000_000,
  parameter int unsigned TIMEOUT_US  = 200_000,
  parameter int unsigned KICK_MIN_US = 40,
  parameter int unsigned RST_MIN_US  = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic feed,
  input  logic power_good,
  input  logic brownout,
  input  logic test_disable,
  output logic reset_n,
  output logic timeout_pulse
);
  localparam int TO_CYC   = int'(us_to_cycles(CLK_HZ, TIMEOUT_US));
  localparam int KICK_CYC = int'(us_to_cycles(CLK_HZ, KICK_MIN_US));
  localparam int RST_CYC  = int'(us_to_cycles(CLK_HZ, RST_MIN_US));

  logic accept, expire, hold;

  wdg_feed_qual #(.KICK_CYC(KICK_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .feed(feed),
    .power_good(power_good), .brownout(brownout), .accept(accept)
  );

  wdg_timeout #(.TO_CYC(TO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept), .hold(hold),
    .disable_i(test_disable), .expire(expire)
  );

  wdg_rst_stretch #(.RST_CYC(RST_CYC)) u_stretch (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .power_good(power_good), .brownout(brownout), .hold(hold)
  );

  assign reset_n       = !hold && !brownout;
  assign timeout_pulse = expire;

  a_r11_no_strobe_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> !timeout_pulse);

endmodule

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;
  localparam int CLK_PERIOD = 10;
  localparam int K   = 4;
  localparam int TO  = 60;
  localparam int RST = 20;

  logic clk = 1'b0;
  logic rst_n, feed, pg, bo, td;
  logic reset_n, tmo;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct { int kind; int stamp; } ev_t;  // kind 0 = strobe, 1 = release
  ev_t exp_q[$];

  wdog_guard #(.CLK_HZ(1_000_000), .TIMEOUT_US(TO), .KICK_MIN_US(K),
               .RST_MIN_US(RST)) u0 (
    .clk(clk), .rst_n(rst_n), .feed(feed), .power_good(pg), .brownout(bo),
    .test_disable(td), .reset_n(reset_n), .timeout_pulse(tmo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int kind, input int st);
    ev_t e;
    e.kind = kind; e.stamp = st;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input int st);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, kind == 0 ? "R5 unexpected strobe" : "R6 unexpected release", st, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind, "R4 event kind", kind, e.kind);
      chk(e.stamp == st, kind == 0 ? "R4 strobe cycle" : "R6 release cycle", st, e.stamp);
    end
  endtask

  // Monitor: scoreboard side
  logic prev_rn = 1'b0;
  logic prev_tmo = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (tmo) observe(0, cyc);
      if (reset_n && !prev_rn) observe(1, cyc);
      if (tmo && prev_tmo) chk(1'b0, "R5 strobe wider than one cycle", 2, 1);
      prev_rn  <= reset_n;
      prev_tmo <= tmo;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int x);
    while (cyc < x) step(1);
  endtask

  task automatic pulse(input int w, output int s);
    s = cyc;
    feed = 1'b1;
    step(w);
    feed = 1'b0;
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    int p, s, t, q, b2, r, exp_t, dummy;
    rst_n = 1'b0; feed = 1'b0; pg = 1'b1; bo = 1'b0; td = 1'b0;
    step(3);
    chk(reset_n == 1'b0, "R1 reset_n in reset", reset_n, 0);
    chk(tmo == 1'b0, "R1 strobe in reset", tmo, 0);
    rst_n = 1'b1; p = cyc;
    push(1, p + RST);
    step(RST - 1);
    chk(reset_n == 1'b0, "R1 power-on stretch", reset_n, 0);
    step(2);
    chk(reset_n == 1'b1, "R6 released after stretch", reset_n, 1);

    // R4: early feed then periodic feeds; R2: glitches do not restart
    pulse(K, s);
    for (int i = 0; i < 4; i++) begin step(30); pulse(K, s); end
    exp_t = s + K + 1 + TO;
    push(0, exp_t); push(1, exp_t + RST + 1);
    step(10); pulse(K - 1, dummy);
    step(10); pulse(1, dummy);
    step(10); pulse(K - 1, dummy);
    chk(reset_n == 1'b1, "R2 running after glitches", reset_n, 1);
    wait_until(exp_t + RST + 2);
    chk(reset_n == 1'b1, "R6 released after timeout", reset_n, 1);

    // R3: long pulse accepted once
    s = cyc; feed = 1'b1;
    exp_t = s + K + 1 + TO;
    push(0, exp_t); push(1, exp_t + RST + 1);
    wait_until(exp_t + 3);
    feed = 1'b0;
    chk(reset_n == 1'b0, "R3 held pulse gave one feed", reset_n, 0);
    wait_until(exp_t + RST + 2);

    // R9 / R8: feeds during power dip ignored, release waits for pg
    pulse(K, s);
    exp_t = s + K + 1 + TO;
    q = exp_t + RST + 15;
    push(0, exp_t); push(1, q + 1);
    step(5); pg = 1'b0;
    step(10); pulse(2 * K, dummy);
    step(5); pulse(2 * K, dummy);
    wait_until(q);
    chk(reset_n == 1'b0, "R8 held while power_good low", reset_n, 0);
    pg = 1'b1;
    step(1);
    chk(reset_n == 1'b1, "R8 release on power_good", reset_n, 1);
    step(2);

    // R7: brownout overrides, reloads stretch
    pulse(K, s);
    step(5);
    bo = 1'b1;
    #1;
    chk(reset_n == 1'b0, "R7 immediate low", reset_n, 0);
    step(RST + 10);
    b2 = cyc; bo = 1'b0;
    push(1, b2 + RST);
    wait_until(b2 + RST - 1);
    chk(reset_n == 1'b0, "R7 stretch after brownout", reset_n, 0);
    wait_until(b2 + RST + 2);

    // R10: test disable parks the timer
    td = 1'b1;
    step(3 * TO);
    chk(reset_n == 1'b1, "R10 no reset while disabled", reset_n, 1);
    t = cyc; td = 1'b0;
    push(0, t + TO); push(1, t + TO + RST + 1);
    wait_until(t + TO + RST + 3);

    // R11: full timeout after release with no feed
    r = t + TO + RST + 1;
    push(0, r + TO); push(1, r + TO + RST + 1);
    wait_until(r + TO + RST + 3);
    chk(reset_n == 1'b1, "R11 second cycle released", reset_n, 1);

    chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
    finish_up();
  end

endmodule